// File: doc/BRIEF.md
# Hourly Chime Tone Generator

This block produces the audible time signal at the end of each hour. It watches the BCD minute and second digits of a running clock. A one-second enable tells it when a new second has begun. It drives a single speaker line with a square wave. Five short low-pitch beeps mark the closing seconds of the hour, and one higher-pitch beep marks the exact rollover.

Each beep starts on the enable pulse of a matching second. It sounds for half a second and then leaves the line low until the next second. Both tone periods are counted in system clock cycles. They are derived from the clock frequency and the two tone frequencies, which are all parameters. The block keeps no time of its own. Time keeping, display and alarm logic are separate blocks that supply the digit inputs.

Top module: `hourly_chime`

## Requirements
- R1: While reset is asserted, and after reset until the first beep starts, `spk` is 0.
- R2: A `sec_tick` pulse while the digits read minute 59 with second 50, 52, 54, 56 or 58 starts a low-pitch beep. Its period is CLK_HZ/LOW_HZ cycles, and the line is high for the first half of each period.
- R3: A `sec_tick` pulse while the digits read minute 00, second 00 starts a high-pitch beep. Its period is CLK_HZ/HIGH_HZ cycles, and the line is high for the first half of each period.
- R4: A beep lasts exactly CLK_HZ/2 cycles, counted from the cycle after the tick. After that, `spk` stays 0 for the rest of the second.
- R5: A tick at any other time produces no sound. This covers odd seconds of minute 59, seconds 48 and 49 of minute 59, second 50 of minute 58, and second 01 of minute 00.
- R6: Every beep restarts its tone phase. `spk` is 1 in the first cycle after the starting tick.
- R7: The digits are only examined on a tick. Matching digits without a tick start nothing. A change of digits during a beep alters neither its pitch nor its length.
- R8: Digits are BCD, with the tens digit in its own 4-bit port and the ones digit in another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse at the start of each second |
| min_tens | input | 4 | BCD tens digit of the minute |
| min_ones | input | 4 | BCD ones digit of the minute |
| sec_tens | input | 4 | BCD tens digit of the second |
| sec_ones | input | 4 | BCD ones digit of the second |
| spk | output | 1 | Speaker drive, square wave while a beep sounds |

## Verification
The bench builds the block with CLK_HZ=64, LOW_HZ=4 and HIGH_HZ=8. This gives a low period of 16 cycles, a high period of 8 cycles and a 32-cycle beep, so one second takes 64 clock cycles. At that scale a whole final minute plus the rollover runs in a couple of thousand cycles. The bench compares every sample of the waveform: phase starts, half-period edges, beep ends, and silent seconds on both sides of the chime window, including digit changes in the middle of a beep.

// File: rtl/chime_pkg.sv
package chime_pkg;

   typedef enum logic [0:0] {
      TONE_LOW  = 1'b0,
      TONE_HIGH = 1'b1
   } tone_e;

   // Convert a value 0..99 to two packed BCD digits {tens, ones}
   function automatic logic [7:0] to_bcd(input int unsigned v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

endpackage

// File: rtl/chime_decode.sv
module chime_decode
   import chime_pkg::*;
#(
   parameter int unsigned WARN_MIN   = 59,
   parameter int unsigned FIRST_SEC  = 50,
   parameter int unsigned WARN_BEEPS = 5,
   parameter int unsigned SPACING    = 2
) (
   input  logic [7:0] min_bcd,
   input  logic [7:0] sec_bcd,
   output logic       hit,
   output tone_e      tone
);

   localparam int unsigned LAST_SEC = FIRST_SEC + SPACING * (WARN_BEEPS - 1);

   generate
      if (WARN_BEEPS < 1 || SPACING < 1 || LAST_SEC > 59 || WARN_MIN > 59) begin : g_bad_cfg
         $error("chime_decode: warning seconds fall outside one minute");
      end
   endgenerate

   logic [WARN_BEEPS-1:0] sec_match;

   generate
      for (genvar i = 0; i < WARN_BEEPS; i++) begin : g_sec
         assign sec_match[i] = (sec_bcd == to_bcd(FIRST_SEC + SPACING * i));
      end
   endgenerate

   logic warn_hit;
   logic top_hit;

   always_comb begin
      warn_hit = (min_bcd == to_bcd(WARN_MIN)) && (|sec_match);
      top_hit  = (min_bcd == 8'h00) && (sec_bcd == 8'h00);
      hit      = warn_hit || top_hit;
      tone     = top_hit ? TONE_HIGH : TONE_LOW;
   end

endmodule

// File: rtl/chime_gate.sv
module chime_gate #(
   parameter int unsigned BEEP_LEN = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);

   localparam int unsigned CW = $clog2(BEEP_LEN);

   generate
      if (BEEP_LEN < 2) begin : g_bad_len
         $error("chime_gate: beep length must be at least two cycles");
      end
   endgenerate

   logic [CW-1:0] len_cnt;
   logic          at_end;

   assign at_end = (len_cnt == CW'(BEEP_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         len_cnt <= '0;
      end else if (start) begin
         active  <= 1'b1;
         len_cnt <= '0;
      end else if (active) begin
         if (at_end) begin
            active  <= 1'b0;
            len_cnt <= '0;
         end else begin
            len_cnt <= len_cnt + 1'b1;
         end
      end
   end

   // R4
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_cnt <= CW'(BEEP_LEN - 1));

   // R4
   len_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && at_end && !start) |=> !active);

endmodule

// File: rtl/chime_tone.sv
module chime_tone
   import chime_pkg::*;
#(
   parameter int unsigned LOW_PER  = 97_656,
   parameter int unsigned HIGH_PER = 48_828
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  tone_e tone_in,
   input  logic  active,
   output logic  wave
);

   localparam int unsigned MAX_PER   = (LOW_PER > HIGH_PER) ? LOW_PER : HIGH_PER;
   localparam int unsigned PW        = $clog2(MAX_PER + 1);
   localparam int unsigned LOW_HALF  = LOW_PER / 2;
   localparam int unsigned HIGH_HALF = HIGH_PER / 2;

   generate
      if (LOW_PER < 2 || HIGH_PER < 2) begin : g_bad_per
         $error("chime_tone: tone periods must be at least two cycles");
      end
   endgenerate

   tone_e         tone_q;
   logic [PW-1:0] phase;
   logic [PW-1:0] per_last;
   logic [PW-1:0] half;

   always_comb begin
      if (tone_q == TONE_HIGH) begin
         per_last = PW'(HIGH_PER - 1);
         half     = PW'(HIGH_HALF);
      end else begin
         per_last = PW'(LOW_PER - 1);
         half     = PW'(LOW_HALF);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tone_q <= TONE_LOW;
         phase  <= '0;
      end else if (start) begin
         tone_q <= tone_in;
         phase  <= '0;
      end else if (active) begin
         phase <= (phase == per_last) ? '0 : phase + 1'b1;
      end
   end

   assign wave = (phase < half);

   // R7
   tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(tone_q));

   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= per_last);

endmodule

// File: rtl/hourly_chime.sv
module hourly_chime
   import chime_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 50_000_000,
   parameter int unsigned LOW_HZ  = 512,
   parameter int unsigned HIGH_HZ = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic [3:0] min_tens,
   input  logic [3:0] min_ones,
   input  logic [3:0] sec_tens,
   input  logic [3:0] sec_ones,
   output logic       spk
);

   localparam int unsigned LOW_PER  = CLK_HZ / LOW_HZ;
   localparam int unsigned HIGH_PER = CLK_HZ / HIGH_HZ;
   localparam int unsigned BEEP_LEN = CLK_HZ / 2;

   generate
      if (LOW_HZ == 0 || HIGH_HZ == 0 || LOW_HZ >= HIGH_HZ) begin : g_bad_hz
         $error("hourly_chime: the top tone must be above the warning tone");
      end
      if (CLK_HZ < 4 * HIGH_HZ) begin : g_bad_clk
         $error("hourly_chime: clock too slow for the high tone");
      end
   endgenerate

   logic  hit;
   tone_e hit_tone;
   logic  start;
   logic  active;
   logic  wave;

   chime_decode #(
      .WARN_MIN   (59),
      .FIRST_SEC  (50),
      .WARN_BEEPS (5),
      .SPACING    (2)
   ) u_decode (
      .min_bcd (
         {min_tens, min_ones}),
      .sec_bcd ({sec_tens, sec_ones}),
      .hit     (hit),
      .tone    (hit_tone)
   );

   assign start = sec_tick && hit;

   chime_gate #(
      .BEEP_LEN (BEEP_LEN)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .active (active)
   );

   chime_tone #(
      .LOW_PER  (LOW_PER),
      .HIGH_PER (HIGH_PER)
   ) u_tone (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tone_in (hit_tone),
      .active  (active),
      .wave    (wave)
   );

   assign spk = active && wave;

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !spk);

   // R6
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> spk);

   // R5
   quiet_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !hit && !active) |=> !spk);

endmodule

// File: tb/tb_hourly_chime.sv
module tb_hourly_chime;

   localparam int CLK_HZ  = 64;
   localparam int LOW_HZ  = 4;
   localparam int HIGH_HZ = 8;
   localparam int LOW_P   = CLK_HZ / LOW_HZ;
   localparam int HIGH_P  = CLK_HZ / HIGH_HZ;
   localparam int BLEN    = CLK_HZ / 2;

   typedef struct {
      logic  val;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [3:0] min_tens = '0, min_ones = '0, sec_tens = '0, sec_ones = '0;
   logic       spk;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   hourly_chime #(
      .CLK_HZ  (CLK_HZ),
      .LOW_HZ  (LOW_HZ),
      .HIGH_HZ (HIGH_HZ)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .min_tens (min_tens),
      .min_ones (min_ones),
      .sec_tens (sec_tens),
      .sec_ones (sec_ones),
      .spk      (spk)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: spk=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_time(input int m, input int s);
      min_tens = 4'(m / 10);
      min_ones = 4'(m % 10);
      sec_tens = 4'(s / 10);
      sec_ones = 4'(s % 10);
   endtask

   // Driver: one second of 64 cycles; pushes the expected waveform
   task automatic run_sec(input int m, input int s, input bit tick,
                          input bit scramble, input string req);
      int per;
      bit beep;
      beep = 1'b0;
      per  = LOW_P;
      if (tick && m == 59 && s >= 50 && s <= 58 && (s % 2) == 0) beep = 1'b1;
      if (tick && m == 0 && s == 0) begin
         beep = 1'b1;
         per  = HIGH_P;
      end
      set_time(m, s);
      sec_tick = tick;
      for (int k = 0; k < CLK_HZ; k++) begin
         exp_t e;
         e.req = req;
         e.val = beep && (k < BLEN) && ((k % per) < (per / 2));
         sb.push_back(e);
      end
      @(negedge clk);
      sec_tick = 1'b0;
      if (scramble) set_time(12, 34);
      repeat (CLK_HZ - 1) @(negedge clk);
   endtask

   // Monitor: compares a little after each rising edge
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(spk, e.val, e.req);
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      set_time(59, 50);
      repeat (3) @(negedge clk);
      check(spk, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(spk, 1'b0, "R1 after reset");

      // R7: matching digits but no tick
      run_sec(59, 50, 1'b0, 1'b0, "R7 no tick");
      run_sec(0, 0, 1'b0, 1'b0, "R7 no tick top");
      // R5: seconds before the window
      run_sec(59, 48, 1'b1, 1'b0, "R5 59:48");
      run_sec(59, 49, 1'b1, 1'b0, "R5 59:49");
      // R2/R4/R6/R8: window with odd seconds silent (R5)
      for (int s = 50; s <= 59; s++)
         run_sec(59, s, 1'b1, 1'b0, (s % 2 == 0) ? "R2 R4 R6 R8 low beep" : "R5 odd second");
      // R3: rollover beep
      run_sec(0, 0, 1'b1, 1'b0, "R3 R4 R6 top beep");
      run_sec(0, 1, 1'b1, 1'b0, "R5 00:01");
      run_sec(58, 50, 1'b1, 1'b0, "R5 58:50");
      // R7: digits change during a beep
      run_sec(59, 52, 1'b1, 1'b1, "R7 scrambled low");
      run_sec(0, 0, 1'b1, 1'b1, "R7 scrambled top");
      run_sec(30, 0, 1'b1, 1'b0, "R5 30:00");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule